// File: doc/BRIEF.md
# Control Register Write-Enable Sequencer

This block guards the nonvolatile clock and control registers of a timekeeping device. A 2-wire slave front-end hands it one-cycle transaction events: start, stop, the slave byte, the register address, each data byte, and an abnormal-end flag. Two volatile latches must be armed in turn by writes to a status register. Only while the second latch is set does a control-register burst reach the storage port. The burst is buffered and released only at a clean stop. It then becomes one write strobe per byte, followed by a self-timed busy window.

At the end of the busy window the register-write latch clears, so every further change needs a fresh unlock. A burst that ends badly (an abort, or a repeated start in place of the stop) commits nothing and leaves both latches as they were. Read transactions pass through without effect. While the busy window runs, the block refuses its slave byte, and the transaction that follows changes nothing.

Top module: `ccr_unlock_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it, `wel`, `rwel`, `busy` and `wr_stb` are 0.
- R2: A status write of 8'h02 sets `wel` and never raises `busy`.
- R3: A status write of 8'h06 sets `rwel` only when `wel` is already 1. Every status value other than 8'h00, 8'h02 and 8'h06, and 8'h06 with `wel` at 0, leaves both latches unchanged. `rwel` is never 1 while `wel` is 0.
- R4: A status write of 8'h00 clears both latches.
- R5: A status write is a transaction with slave byte 8'hDE, address STATUS_ADDR and one or more data bytes, of which the first is used. It takes effect only at a stop. An abort, or an abort in the same cycle as the stop, discards it.
- R6: A control write (slave 8'hDE, address at or below CCR_LAST) made while `rwel` is 1 produces one `wr_stb` cycle per byte at consecutive addresses, in arrival order. The first strobe comes two cycles after the cycle in which `ev_stop` is high.
- R7: `busy` is high from the cycle after the stop through BUSY_CYCLES cycles after the last strobe, which is n+BUSY_CYCLES+1 cycles for n strobes. `rwel` falls in the same cycle as `busy`, and `wel` stays set.
- R8: A control write made while `rwel` is 0 produces no strobe and no busy window.
- R9: A control write that ends with an abort, or with a repeated start before its stop, produces no strobe and leaves `rwel` at 1.
- R10: A read transaction (slave byte 8'hDF) changes neither latch, including between the two unlock steps.
- R11: A burst that starts above CCR_LAST produces no strobe and no busy window, and leaves `rwel` at 1. Bytes whose address would pass CCR_LAST are dropped.
- R12: While `busy` is 1, `slv_ack` stays 0 and the refused transaction changes no latch and writes nothing.
- R13: At most MAX_BYTES data bytes of one burst are written. Later bytes are discarded.
- R14: `slv_ack` is 1 in the same cycle as `ev_slave` when the slave byte's upper seven bits are 7'b1101111 and `busy` is 0. It is 0 for any other slave byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_start | input | 1 | Start condition seen (one cycle) |
| ev_stop | input | 1 | Stop condition seen (one cycle) |
| ev_abort | input | 1 | Transaction ended abnormally (one cycle) |
| ev_slave | input | 1 | Slave byte valid |
| slave_byte | input | 8 | Slave byte including read/write bit |
| ev_addr | input | 1 | Register address byte valid |
| addr_byte | input | 8 | Register address |
| ev_data | input | 1 | Written data byte valid |
| data_byte | input | 8 | Written data byte |
| slv_ack | output | 1 | Acknowledge for the slave byte |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| busy | output | 1 | Commit and self-timed write in progress |
| wr_stb | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |

## Verification
Two functions can fall in the same cycle. The first is the stop that would commit a burst. The second is the abort flag, which must cancel that commit. The bench drives `ev_stop` and `ev_abort` in one cycle, after both a status write and an armed control write. It judges the result at the ports: no strobe, no busy window, and latches unchanged. A second pairing is the end of the busy window against a new transaction. A status clear is sent while the write is still timing out. It must be refused, so `wel` stays set while `rwel` falls as the window closes.

// File: rtl/ccr_seq_pkg.sv
// Shared constants and types for the control-register write-enable sequencer.
// Assumes 8-bit register addresses and data bytes.
package ccr_seq_pkg;
    localparam int unsigned BYTE_W      = 8;
    localparam logic [7:0]  SLV_CTRL_WR = 8'hDE;
    localparam logic [6:0]  SLV_CTRL_ID = 7'h6F;
    localparam logic [7:0]  ST_CLEAR    = 8'h00;
    localparam logic [7:0]  ST_ARM_WE   = 8'h02;
    localparam logic [7:0]  ST_ARM_RWE  = 8'h06;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_DRAIN = 2'd1,
        ENG_WAIT  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/ccr_txn_capture.sv
// Follows the transaction events from the 2-wire front-end and buffers one
// write burst aimed at this block. At a clean stop it pulses fin for one cycle.
// fin_addr, fin_cnt and fin_data stay stable until the next start.
// Assumes at most one event input is high per cycle, or else abort > stop > start.
module ccr_txn_capture
    import ccr_seq_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int CW = $clog2(MAX_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ev_start,
    input  logic                        ev_stop,
    input  logic                        ev_abort,
    input  logic                        ev_slave,
    input  logic [7:0]                  slave_byte,
    input  logic                        ev_addr,
    input  logic [7:0]                  addr_byte,
    input  logic                        ev_data,
    input  logic [7:0]                  data_byte,
    input  logic                        busy,
    output logic                        slv_ack,
    output logic                        fin,
    output logic [7:0]                  fin_addr,
    output logic [CW-1:0]               fin_cnt,
    output logic [MAX_BYTES*BYTE_W-1:0] fin_data
);
    logic          mine_q;
    logic          have_addr_q;
    logic [7:0]    addr_q;
    logic [CW-1:0] cnt_q;
    logic          take_byte;

    // Acknowledge our own device identifier only when no write is in progress.
    always_comb slv_ack = ev_slave && (slave_byte[7:1] == SLV_CTRL_ID) && !busy;

    // A data byte is stored while an address is held and the buffer has room.
    always_comb take_byte = ev_data && !ev_abort && !ev_stop && !ev_start && !ev_slave
                            && !ev_addr && have_addr_q && (cnt_q < CW'(MAX_BYTES));

    // Transaction state: ownership, address capture, byte count and finish pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mine_q      <= 1'b0;
            have_addr_q <= 1'b0;
            addr_q      <= '0;
            cnt_q       <= '0;
            fin         <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (ev_abort) begin
                mine_q      <= 1'b0;
                have_addr_q <= 1'b0;
            end else if (ev_stop) begin
                fin         <= mine_q && have_addr_q && (cnt_q != '0);
                mine_q      <= 1'b0;
                have_addr_q <= 1'b0;
            end else if (ev_start) begin
                mine_q      <= 1'b0;
                have_addr_q <= 1'b0;
                cnt_q       <= '0;
            end else if (ev_slave) begin
                mine_q <= slv_ack && (slave_byte == SLV_CTRL_WR);
            end else if (ev_addr && mine_q && !have_addr_q) begin
                have_addr_q <= 1'b1;
                addr_q      <= addr_byte;
            end else if (take_byte) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // One buffer slot per byte position; each slot loads when it is the next free one.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
        logic [7:0] slot_q;
        // Load the slot from the incoming byte when the count points at it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (take_byte && (cnt_q == CW'(g)))
                slot_q <= data_byte;
        end
        assign fin_data[g*BYTE_W +: BYTE_W] = slot_q;
    end

    assign fin_addr = addr_q;
    assign fin_cnt  = cnt_q;
endmodule

// File: rtl/ccr_status_latches.sv
// Holds the two volatile unlock latches. It applies finished status writes and
// clears the register-write latch when a nonvolatile cycle completes.
// Assumes a status write and a completion never come in the same cycle.
module ccr_status_latches
    import ccr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       st_wr,
    input  logic [7:0] st_val,
    input  logic       rwel_clr,
    output logic       wel,
    output logic       rwel
);
    // Decode the status value; unknown values leave both latches alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
        end else if (st_wr) begin
            case (st_val)
                ST_CLEAR: begin
                    wel  <= 1'b0;
                    rwel <= 1'b0;
                end
                ST_ARM_WE:  wel <= 1'b1;
                ST_ARM_RWE: if (wel) rwel <= 1'b1;
                default: ;
            endcase
        end else if (rwel_clr) begin
            rwel <= 1'b0;
        end
    end
endmodule

// File: rtl/ccr_commit_engine.sv
// Replays a buffered burst as one register write strobe per cycle, then holds
// busy for BUSY_CYCLES cycles. It pulses done in the last busy cycle.
// Assumes go_cnt is at least 1 and already clipped to the register range.
module ccr_commit_engine
    import ccr_seq_pkg::*;
#(
    parameter int MAX_BYTES   = 8,
    parameter int BUSY_CYCLES = 1000,
    localparam int CW = $clog2(MAX_BYTES + 1),
    localparam int TW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic [7:0]                  go_addr,
    input  logic [CW-1:0]               go_cnt,
    input  logic [MAX_BYTES*BYTE_W-1:0] go_data,
    output logic                        busy,
    output logic                        wr_stb,
    output logic [7:0]                  wr_addr,
    output logic [7:0]                  wr_data,
    output logic                        done
);
    eng_state_t                  state_q;
    logic [CW-1:0]               idx_q;
    logic [CW-1:0]               n_q;
    logic [7:0]                  base_q;
    logic [MAX_BYTES*BYTE_W-1:0] data_q;
    logic [TW-1:0]               timer_q;

    // Outputs decoded from the current phase and byte index.
    always_comb begin
        busy    = (state_q != ENG_IDLE);
        wr_stb  = (state_q == ENG_DRAIN);
        wr_addr = base_q + 8'(idx_q);
        done    = (state_q == ENG_WAIT) && (timer_q == TW'(BUSY_CYCLES - 1));
        wr_data = '0;
        for (int i = 0; i < MAX_BYTES; i++)
            if (idx_q == CW'(i)) wr_data = data_q[i*BYTE_W +: BYTE_W];
    end

    // Phase sequencing: load, drain the bytes, then time out the write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            idx_q   <= '0;
            n_q     <= '0;
            base_q  <= '0;
            data_q  <= '0;
            timer_q <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: if (go) begin
                    state_q <= ENG_DRAIN;
                    idx_q   <= '0;
                    n_q     <= go_cnt;
                    base_q  <= go_addr;
                    data_q  <= go_data;
                end
                ENG_DRAIN: if (idx_q == n_q - CW'(1)) begin
                    state_q <= ENG_WAIT;
                    timer_q <= '0;
                end else begin
                    idx_q <= idx_q + CW'(1);
                end
                ENG_WAIT: if (done) state_q <= ENG_IDLE;
                          else      timer_q <= timer_q + TW'(1);
                default: state_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ccr_unlock_seq.sv
// Top of the control-register write-enable sequencer. It routes finished
// bursts either to the unlock latches (status address) or to the commit engine
// (defined control range, register-write latch set). Everything else is dropped.
// Assumes STATUS_ADDR lies above CCR_LAST and that BUSY_CYCLES is at least 1.
module ccr_unlock_seq
    import ccr_seq_pkg::*;
#(
    parameter int MAX_BYTES   = 8,
    parameter int CCR_LAST    = 19,
    parameter int STATUS_ADDR = 63,
    parameter int BUSY_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_start,
    input  logic       ev_stop,
    input  logic       ev_abort,
    input  logic       ev_slave,
    input  logic [7:0] slave_byte,
    input  logic       ev_addr,
    input  logic [7:0] addr_byte,
    input  logic       ev_data,
    input  logic [7:0] data_byte,
    output logic       slv_ack,
    output logic       wel,
    output logic       rwel,
    output logic       busy,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    localparam int CW = $clog2(MAX_BYTES + 1);

    logic                        fin;
    logic [7:0]                  fin_addr;
    logic [CW-1:0]               fin_cnt;
    logic [MAX_BYTES*BYTE_W-1:0] fin_data;
    logic                        is_status, in_range, st_wr, go, eng_busy, done;
    logic [CW-1:0]               clip_cnt;
    int                          room;

    ccr_txn_capture #(.MAX_BYTES(MAX_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_abort(ev_abort),
        .ev_slave(ev_slave), .slave_byte(slave_byte),
        .ev_addr(ev_addr), .addr_byte(addr_byte),
        .ev_data(ev_data), .data_byte(data_byte),
        .busy(busy), .slv_ack(slv_ack),
        .fin(fin), .fin_addr(fin_addr), .fin_cnt(fin_cnt), .fin_data(fin_data)
    );

    // Route the finished burst and clip its length to the defined range.
    always_comb begin
        is_status = (fin_addr == 8'(STATUS_ADDR));
        in_range  = (int'(fin_addr) <= CCR_LAST);
        room      = CCR_LAST + 1 - int'(fin_addr);
        clip_cnt  = (int'(fin_cnt) > room) ? CW'(room) : fin_cnt;
        st_wr     = fin && is_status;
        go        = fin && !is_status && in_range && rwel;
        busy      = eng_busy || go;
    end

    ccr_status_latches u_lat (
        .clk(clk), .rst_n(rst_n),
        .st_wr(st_wr), .st_val(fin_data[7:0]), .rwel_clr(done),
        .wel(wel), .rwel(rwel)
    );

    ccr_commit_engine #(.MAX_BYTES(MAX_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .go(go), .go_addr(fin_addr), .go_cnt(clip_cnt), .go_data(fin_data),
        .busy(eng_busy), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done)
    );
endmodule

// File: rtl/ccr_unlock_chk.sv
// Property checker for the sequencer. It is bound to every instance of the top.
// Assumes the same CCR_LAST as the instance it watches.
module ccr_unlock_chk #(
    parameter int CCR_LAST = 19
) (
    input logic       clk,
    input logic       rst_n,
    input logic       slv_ack,
    input logic       wel,
    input logic       rwel,
    input logic       busy,
    input logic       wr_stb,
    input logic [7:0] wr_addr
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!wel && !rwel && !busy && !wr_stb));

    assert_wel_rise_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !busy);

    assert_rwel_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel);

    assert_strobe_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy);

    assert_rwel_drops_with_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !rwel);

    assert_strobe_needs_rwel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> rwel);

    assert_strobe_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (int'(wr_addr) <= CCR_LAST));

    assert_no_ack_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !slv_ack);
endmodule

bind ccr_unlock_seq ccr_unlock_chk #(.CCR_LAST(CCR_LAST)) u_chk (
    .clk(clk), .rst_n(rst_n), .slv_ack(slv_ack), .wel(wel), .rwel(rwel),
    .busy(busy), .wr_stb(wr_stb), .wr_addr(wr_addr)
);

// File: tb/ccr_unlock_seq_test.sv
// Sweep bench: every status value from each latch state, every burst start
// and length around the range edges, plus abort, read and busy corner cases.
module ccr_unlock_seq_test;
    localparam int MB = 8, LAST = 19, STA = 63, BC = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ev_start = 0, ev_stop = 0, ev_abort = 0, ev_slave = 0, ev_addr = 0, ev_data = 0;
    logic [7:0] slave_byte = 0, addr_byte = 0, data_byte = 0;
    logic slv_ack, wel, rwel, busy, wr_stb;
    logic [7:0] wr_addr, wr_data;

    int checks = 0, errors = 0, cyc = 0, stop_cyc = 0, first_stb = -1;
    int nstb = 0, busy_cyc = 0;
    logic [7:0] la [64];
    logic [7:0] ld [64];
    logic [7:0] dbuf [16];
    bit done_flag = 0;

    ccr_unlock_seq #(.MAX_BYTES(MB), .CCR_LAST(LAST), .STATUS_ADDR(STA), .BUSY_CYCLES(BC)) uut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop), .ev_abort(ev_abort),
        .ev_slave(ev_slave), .slave_byte(slave_byte), .ev_addr(ev_addr), .addr_byte(addr_byte),
        .ev_data(ev_data), .data_byte(data_byte), .slv_ack(slv_ack), .wel(wel), .rwel(rwel),
        .busy(busy), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    // Log strobes and busy cycles away from the active edge.
    always @(negedge clk) begin
        if (wr_stb) begin
            if (nstb < 64) begin la[nstb] = wr_addr; ld[nstb] = wr_data; end
            if (first_stb < 0) first_stb = cyc;
            nstb++;
        end
        if (busy) busy_cyc++;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_log;
        nstb = 0; busy_cyc = 0; first_stb = -1;
    endtask

    // Send one transaction; endm 0 stop, 1 abort, 2 repeated start, 3 stop with abort.
    task automatic txn(logic [7:0] sb, logic [7:0] a, int n, int endm, output bit ack);
        ev_start = 1; @(negedge clk); ev_start = 0; @(negedge clk);
        slave_byte = sb; ev_slave = 1; #1 ack = slv_ack; @(negedge clk); ev_slave = 0; @(negedge clk);
        if (!sb[0]) begin
            addr_byte = a; ev_addr = 1; @(negedge clk); ev_addr = 0; @(negedge clk);
            for (int i = 0; i < n; i++) begin
                data_byte = dbuf[i]; ev_data = 1; @(negedge clk); ev_data = 0; @(negedge clk);
            end
        end
        if (endm == 2) begin ev_start = 1; @(negedge clk); ev_start = 0; @(negedge clk); end
        stop_cyc = cyc;
        ev_stop  = (endm != 1);
        ev_abort = (endm == 1 || endm == 3);
        @(negedge clk); ev_stop = 0; ev_abort = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic st_write(logic [7:0] v, int endm = 0);
        bit ack;
        dbuf[0] = v;
        txn(8'hDE, 8'(STA), 1, endm, ack);
    endtask

    // Put the latches in state 0 (clear), 1 (wel) or 2 (wel and rwel).
    task automatic set_state(int s);
        st_write(8'h00);
        if (s >= 1) st_write(8'h02);
        if (s == 2) st_write(8'h06);
    endtask

    task automatic wait_idle;
        for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({wel, rwel, busy, wr_stb} == 4'b0, "R1 reset outputs", int'({wel, rwel, busy, wr_stb}), 0);
        rst_n = 1; @(negedge clk);
        chk({wel, rwel, busy, wr_stb} == 4'b0, "R1 after reset", int'({wel, rwel, busy, wr_stb}), 0);

        // R2 R3 R4: every status value from each latch state
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 256; v++) begin
                int ew, er, act, exp;
                set_state(s);
                clr_log();
                st_write(8'(v));
                ew = (s >= 1); er = (s == 2);
                if (v == 0) begin ew = 0; er = 0; end
                else if (v == 2) ew = 1;
                else if (v == 6 && ew == 1) er = 1;
                act = {wel, rwel, 1'b0} | ((busy_cyc != 0) ? 1 : 0);
                exp = ew * 4 + er * 2;
                chk(act == exp, (v == 0) ? "R4 clear" : (v == 2) ? "R2 arm wel" : "R3 status value",
                    act, exp);
            end
        end

        // R5: status write discarded by abort, and by abort together with stop
        set_state(0); st_write(8'h02, 1);
        chk(wel == 0, "R5 abort drops status write", wel, 0);
        st_write(8'h02, 3);
        chk(wel == 0, "R5 stop with abort drops status write", wel, 0);
        st_write(8'h02, 0);
        chk(wel == 1, "R5 stop applies status write", wel, 1);

        // R6 R7 R11 R13: sweep start address and burst length
        for (int a = 0; a <= LAST + 2; a++) begin
            for (int n = 1; n <= MB + 2; n++) begin
                int en, bad;
                set_state(2);
                for (int i = 0; i < 16; i++) dbuf[i] = 8'((a * 7 + i * 13 + 1) & 255);
                clr_log();
                txn(8'hDE, 8'(a), n, 0, ack);
                wait_idle(); @(negedge clk);
                en = (a > LAST) ? 0 : ((n < MB ? n : MB) < (LAST + 1 - a) ? (n < MB ? n : MB) : (LAST + 1 - a));
                chk(nstb == en, (n > MB) ? "R13 strobe count" : (a > LAST) ? "R11 strobe count" : "R6 strobe count",
                    nstb, en);
                bad = 0;
                for (int i = 0; i < en && i < 64; i++)
                    if (la[i] != 8'(a + i) || ld[i] != dbuf[i]) bad++;
                chk(bad == 0, "R6 strobe address and data order", bad, 0);
                if (en > 0) chk(first_stb - stop_cyc == 2, "R6 first strobe latency", first_stb - stop_cyc, 2);
                chk(busy_cyc == ((en > 0) ? en + BC + 1 : 0), "R7 busy length", busy_cyc,
                    (en > 0) ? en + BC + 1 : 0);
                chk({wel, rwel} == ((en > 0) ? 2'b10 : 2'b11), (en > 0) ? "R7 latches after write" : "R11 latches kept",
                    int'({wel, rwel}), (en > 0) ? 2 : 3);
            end
        end

        // R8: control write without rwel
        set_state(1); clr_log(); dbuf[0] = 8'h55;
        txn(8'hDE, 8'h03, 1, 0, ack);
        chk(nstb == 0 && busy_cyc == 0, "R8 locked write ignored", nstb + busy_cyc, 0);

        // R9: abort, repeated start, and abort in the stop cycle
        for (int m = 1; m < 4; m++) begin
            set_state(2); clr_log();
            txn(8'hDE, 8'h02, 2, m, ack);
            chk(nstb == 0 && busy_cyc == 0, "R9 aborted write no strobe", nstb + busy_cyc, 0);
            chk(rwel == 1, "R9 rwel kept after abnormal end", rwel, 1);
        end

        // R10: reads between and after the unlock steps
        set_state(0); st_write(8'h02);
        txn(8'hDF, 8'h00, 0, 0, ack);
        chk(ack == 1, "R14 read slave acked", ack, 1);
        st_write(8'h06);
        txn(8'hDF, 8'h00, 0, 0, ack);
        chk({wel, rwel} == 2'b11, "R10 reads keep latches", int'({wel, rwel}), 3);

        // R14: foreign slave byte is not acked
        txn(8'hA0, 8'h00, 0, 0, ack);
        chk(ack == 0, "R14 foreign slave not acked", ack, 0);

        // R12: status clear sent during busy is refused and ignored
        set_state(2); clr_log();
        dbuf[0] = 8'h11; dbuf[1] = 8'h22;
        txn(8'hDE, 8'h00, 2, 0, ack);
        chk(ack == 1, "R14 control slave acked when idle", ack, 1);
        dbuf[0] = 8'h00;
        txn(8'hDE, 8'(STA), 1, 0, ack);
        chk(ack == 0, "R12 no ack while busy", ack, 0);
        wait_idle(); @(negedge clk);
        chk({wel, rwel} == 2'b10, "R12 refused clear ignored", int'({wel, rwel}), 2);
        chk(nstb == 2, "R12 no extra strobes", nstb, 2);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule